// File: doc/BRIEF.md
# Input Power Qualifier with Event-Dependent Deglitch

This block decides whether the supply feeding a single-cell charger can be trusted. It takes three already-hysteresed comparator flags: input above the undervoltage lockout level, input above the battery plus a small margin, and input above the overvoltage level. Each flag is filtered by its own deglitch timer before it reaches the outputs. The timers count pulses of a free-running 1 µs timebase tick.

The delay that applies depends on two things: which way the flag is moving, and whether the charger enable input is high. When the charger is disabled, some transitions act at once, so the block reacts quickly while nothing is drawing current. When the charger is enabled, it rides through short disturbances instead. If a pending change reverts before its delay runs out, the timer starts over and the output keeps its value.

The outputs are a power-good indication, an overvoltage fault, and a supply-valid signal. The supply-valid signal gates both the charger and the auxiliary regulator. While the input is below lockout, every other input is ignored and all outputs stay inactive.

Top module: `inpwr_qualifier`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises with all flags low, pwr_good, ovp_fault and supply_ok are all 0.
- R2: pwr_good is 1 only when the filtered lockout flag is 1, the filtered battery-margin flag is 1 and the filtered overvoltage flag is 0.
- R3: supply_ok is 1 exactly when the filtered lockout flag is 1 and the filtered overvoltage flag is 0. It does not depend on the battery-margin flag.
- R4: When above_ovp rises, ovp_fault goes to 1 after 100 ticks if chg_en is 1. If chg_en is 0, it goes to 1 at the first clock edge. While ovp_fault is 1, supply_ok and pwr_good are 0.
- R5: When above_ovp falls, ovp_fault clears after 450 ticks if chg_en is 1, and after 500 ticks if chg_en is 0.
- R6: When above_bat falls, pwr_good drops after 32000 ticks if chg_en is 1. If chg_en is 0, it drops at the first clock edge. supply_ok is unaffected.
- R7: When above_bat rises, the filtered battery-margin flag sets after 500 ticks, whatever the value of chg_en.
- R8: When above_uvlo falls, all outputs drop at the first clock edge. When above_uvlo rises, the filtered lockout flag sets after 230 ticks.
- R9: While above_uvlo is 0, above_bat, above_ovp and chg_en have no effect: all outputs stay 0, and the battery-margin and overvoltage filters are held cleared.
- R10: If a flag returns to its filtered value before the delay expires, the output does not change, and the next change starts a full new delay.
- R11: Delays advance only on clock edges where tick_us is 1. An output with an N-tick delay changes at the edge that samples the N-th tick after the flag changes, provided the flag is held throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset to the unpowered state |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| chg_en | input | 1 | Charger enable; selects the enabled or disabled delay set |
| above_uvlo | input | 1 | Comparator: input above undervoltage lockout |
| above_bat | input | 1 | Comparator: input above battery plus margin |
| above_ovp | input | 1 | Comparator: input above overvoltage threshold |
| pwr_good | output | 1 | Qualified power-good indication |
| ovp_fault | output | 1 | Qualified overvoltage fault |
| supply_ok | output | 1 | Gate for the charger and the auxiliary regulator |

## Verification
A table walks the supply through power-up, overvoltage entry and exit, sleep entry and exit, and finally lockout. Each of these is run with chg_en high and again with chg_en low. At every step the outputs are sampled one edge before the expected change and again at the edge of the change, so an off-by-one count or a swapped enable-state delay shows up. Directed cases then cover the following:
- Overvoltage and enable toggled during lockout, which must have no effect.
- A pending overvoltage exit interrupted by a one-cycle reversal, which must restart the count.
- A long stretch without tick pulses, during which nothing may advance.
- A mid-run reset, after which every output must read inactive.

// File: rtl/pq_pkg.sv
package pq_pkg;

   // filtered comparator flags handed from the filters to the status logic
   typedef struct packed {
      logic uv_ok;   // input above lockout, deglitched
      logic bat_ok;  // input above battery plus margin, deglitched
      logic ovp;     // input above overvoltage level, deglitched
   } pq_flags_t;

   function automatic int pq_max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/pq_deglitch.sv
module pq_deglitch
   import pq_pkg::*;
#(
   parameter int RISE_EN  = 1,   // ticks for 0->1 while enabled
   parameter int RISE_DIS = 1,   // ticks for 0->1 while disabled
   parameter int FALL_EN  = 1,   // ticks for 1->0 while enabled
   parameter int FALL_DIS = 1,   // ticks for 1->0 while disabled
   parameter bit INIT     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic en,
   input  logic raw,
   output logic filt
);

   localparam int MAXD = pq_max4(RISE_EN, RISE_DIS, FALL_EN, FALL_DIS);
   localparam int CW   = (MAXD < 2) ? 1 : $clog2(MAXD + 1);
   localparam int CW1  = CW + 1;

   initial begin
      assert (RISE_EN >= 0 && RISE_DIS >= 0 && FALL_EN >= 0 && FALL_DIS >= 0)
         else $error("pq_deglitch: negative delay");
      assert (MAXD < (1 << 24))
         else $error("pq_deglitch: delay too large");
   end

   generate
      if (MAXD == 0) begin : g_pass
         // every delay is zero: one register stage, nothing to count
         logic unused_inputs;
         assign unused_inputs = ^{tick, en};
         always_ff @(posedge clk) begin
            if (!rst_n)   filt <= INIT;
            else if (clr) filt <= INIT;
            else          filt <= raw;
         end
      end else begin : g_count
         logic [CW-1:0] cnt;
         logic [CW-1:0] need;
         logic          expire;

         always_comb begin
            if (raw) need = en ? CW'(RISE_EN) : CW'(RISE_DIS);
            else     need = en ? CW'(FALL_EN) : CW'(FALL_DIS);
            expire = (need == '0) ||
                     (tick && (({1'b0, cnt} + CW1'(1)) >= {1'b0, need}));
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               filt <= INIT;
               cnt  <= '0;
            end else if (clr) begin
               filt <= INIT;
               cnt  <= '0;
            end else if (raw == filt) begin
               cnt  <= '0;               // reverted: restart next time
            end else if (expire) begin
               filt <= raw;
               cnt  <= '0;
            end else if (tick) begin
               cnt  <= cnt + CW'(1);
            end
         end

         // R11: no tick, nonzero delay -> filtered value holds
         a_r11_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && !tick && raw != filt && need != '0) |=> $stable(filt));
      end
   endgenerate

   // R10: agreement between raw and filtered value keeps the output
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && raw == filt) |=> $stable(filt));

   // R10: output only ever moves toward the sampled raw value
   a_r10_target: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (filt == $past(filt) || filt == $past(raw)));

   // R9: clear forces the initial value
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (filt == INIT));

endmodule

// File: rtl/pq_status.sv
module pq_status
   import pq_pkg::*;
(
   input  pq_flags_t flg,
   output logic      pwr_good,
   output logic      ovp_fault,
   output logic      supply_ok
);

   always_comb begin
      supply_ok = flg.uv_ok & ~flg.ovp;
      pwr_good  = flg.uv_ok & flg.bat_ok & ~flg.ovp;
      ovp_fault = flg.uv_ok & flg.ovp;
   end

endmodule

// File: rtl/inpwr_qualifier.sv
module inpwr_qualifier
   import pq_pkg::*;
#(
   parameter int UV_RISE_US      = 230,
   parameter int BAT_RISE_US     = 500,
   parameter int BAT_FALL_EN_US  = 32000,
   parameter int BAT_FALL_DIS_US = 0,
   parameter int OVP_RISE_EN_US  = 100,
   parameter int OVP_RISE_DIS_US = 0,
   parameter int OVP_FALL_EN_US  = 450,
   parameter int OVP_FALL_DIS_US = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_us,
   input  logic chg_en,
   input  logic above_uvlo,
   input  logic above_bat,
   input  logic above_ovp,
   output logic pwr_good,
   output logic ovp_fault,
   output logic supply_ok
);

   pq_flags_t flg;
   logic      hold_clr;

   // everything except the lockout filter is held cleared below lockout
   assign hold_clr = ~above_uvlo;

   pq_deglitch #(
      .RISE_EN(UV_RISE_US), .RISE_DIS(UV_RISE_US),
      .FALL_EN(0),          .FALL_DIS(0),
      .INIT(1'b0)
   ) u_uv (
      .clk(clk), .rst_n(rst_n), .clr(1'b0), .tick(tick_us), .en(chg_en),
      .raw(above_uvlo), .filt(flg.uv_ok)
   );

   pq_deglitch #(
      .RISE_EN(BAT_RISE_US),    .RISE_DIS(BAT_RISE_US),
      .FALL_EN(BAT_FALL_EN_US), .FALL_DIS(BAT_FALL_DIS_US),
      .INIT(1'b0)
   ) u_bat (
      .clk(clk), .rst_n(rst_n), .clr(hold_clr), .tick(tick_us), .en(chg_en),
      .raw(above_bat), .filt(flg.bat_ok)
   );

   pq_deglitch #(
      .RISE_EN(OVP_RISE_EN_US), .RISE_DIS(OVP_RISE_DIS_US),
      .FALL_EN(OVP_FALL_EN_US), .FALL_DIS(OVP_FALL_DIS_US),
      .INIT(1'b0)
   ) u_ovp (
      .clk(clk), .rst_n(rst_n), .clr(hold_clr), .tick(tick_us), .en(chg_en),
      .raw(above_ovp), .filt(flg.ovp)
   );

   pq_status u_stat (
      .flg(flg), .pwr_good(pwr_good), .ovp_fault(ovp_fault), .supply_ok(supply_ok)
   );

   // R8 / R9: lockout drops every output on the next edge
   a_r8_uv_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !above_uvlo |=> (!pwr_good && !supply_ok && !ovp_fault));

   // R4: disabled overvoltage entry is immediate
   a_r4_ovp_now: assert property (@(posedge clk) disable iff (!rst_n)
      (flg.uv_ok && above_uvlo && !chg_en && above_ovp) |=> ovp_fault);

   // R6: disabled sleep entry drops power-good at once
   a_r6_sleep_now: assert property (@(posedge clk) disable iff (!rst_n)
      (!chg_en && $fell(above_bat)) |=> !pwr_good);

   // R4: fault excludes the supply gate
   a_r4_fault_gates: assert property (@(posedge clk) disable iff (!rst_n)
      ovp_fault |-> (!supply_ok && !pwr_good));

endmodule

// File: tb/sim_inpwr_qualifier.sv
module sim_inpwr_qualifier;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_us = 1'b1;
   logic chg_en = 1'b1;
   logic above_uvlo = 1'b0;
   logic above_bat = 1'b0;
   logic above_ovp = 1'b0;
   logic pwr_good, ovp_fault, supply_ok;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   inpwr_qualifier u0 (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .chg_en(chg_en),
      .above_uvlo(above_uvlo), .above_bat(above_bat), .above_ovp(above_ovp),
      .pwr_good(pwr_good), .ovp_fault(ovp_fault), .supply_ok(supply_ok)
   );

   // row: {uv,bat,ovp,en}[26:23] wait[22:7] {pg,ovp,sok}[6:4] req[3:0]
   localparam int NV = 18;
   localparam logic [26:0] VEC [NV] = '{
      {4'b1101, 16'd229,   3'b000, 4'd8},  // R8 lockout exit, one short
      {4'b1101, 16'd1,     3'b001, 4'd8},  // R8 lockout exit done, R3 supply ok
      {4'b1101, 16'd269,   3'b001, 4'd7},  // R7 margin rise, one short
      {4'b1101, 16'd1,     3'b101, 4'd7},  // R7 power good
      {4'b1111, 16'd99,    3'b101, 4'd4},  // R4 enabled ovp, one short
      {4'b1111, 16'd1,     3'b010, 4'd4},  // R4 fault set
      {4'b1101, 16'd449,   3'b010, 4'd5},  // R5 enabled exit, one short
      {4'b1101, 16'd1,     3'b101, 4'd5},  // R5 cleared
      {4'b1110, 16'd1,     3'b010, 4'd4},  // R4 disabled immediate
      {4'b1100, 16'd499,   3'b010, 4'd5},  // R5 disabled exit, one short
      {4'b1100, 16'd1,     3'b101, 4'd5},  // R5 cleared
      {4'b1000, 16'd1,     3'b001, 4'd6},  // R6 disabled sleep immediate
      {4'b1100, 16'd499,   3'b001, 4'd7},  // R7 disabled, one short
      {4'b1100, 16'd1,     3'b101, 4'd7},  // R7 disabled
      {4'b1001, 16'd31999, 3'b101, 4'd6},  // R6 enabled sleep, one short
      {4'b1001, 16'd1,     3'b001, 4'd6},  // R6 enabled sleep, R3 supply kept
      {4'b1101, 16'd500,   3'b101, 4'd2},  // R2 all good again
      {4'b0101, 16'd1,     3'b000, 4'd8}   // R8 immediate lockout
   };

   task automatic chk(input string req, input string what,
                      input logic [2:0] act, input logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: pg/ovp/sok actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [2:0] outs();
      return {pwr_good, ovp_fault, supply_ok};
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      edges(3);
      chk("R1", "in reset", outs(), 3'b000);
      rst_n = 1'b1;
      edges(1);
      chk("R1", "after reset", outs(), 3'b000);

      for (int i = 0; i < NV; i++) begin
         {above_uvlo, above_bat, above_ovp, chg_en} = VEC[i][26:23];
         edges(int'(VEC[i][22:7]));
         chk($sformatf("R%0d", VEC[i][3:0]), $sformatf("row %0d", i), outs(), VEC[i][6:4]);
      end

      // R9: below lockout, other inputs ignored
      above_ovp = 1'b1; chg_en = 1'b0; above_bat = 1'b1;
      edges(10);
      chk("R9", "ovp during lockout", outs(), 3'b000);
      chg_en = 1'b1; edges(3); chg_en = 1'b0; edges(3);
      chk("R9", "enable toggle during lockout", outs(), 3'b000);
      above_uvlo = 1'b1;
      edges(229);
      chk("R9", "still locked", outs(), 3'b000);
      edges(1);
      chk("R4", "fault visible at lockout exit", outs(), 3'b010);

      // R10: reversal restarts the exit count
      chg_en = 1'b1; above_ovp = 1'b0;
      edges(300);
      chk("R10", "exit pending", outs(), 3'b010);
      above_ovp = 1'b1; edges(1);
      above_ovp = 1'b0;
      edges(449);
      chk("R10", "restarted count one short", outs(), 3'b010);
      edges(1);
      chk("R10", "restarted count done", outs(), 3'b101);

      // R11: no ticks, no progress
      tick_us = 1'b0; above_ovp = 1'b1;
      edges(300);
      chk("R11", "no tick hold", outs(), 3'b101);
      tick_us = 1'b1;
      edges(99);
      chk("R11", "ticks one short", outs(), 3'b101);
      edges(1);
      chk("R11", "ticks done", outs(), 3'b010);

      // R1: reset mid-run with flags high
      rst_n = 1'b0;
      edges(1);
      chk("R1", "mid-run reset", outs(), 3'b000);
      rst_n = 1'b1; above_ovp = 1'b0;
      edges(1);
      chk("R1", "restart from unpowered", outs(), 3'b000);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule